// File: doc/BRIEF.md
# I2C Multi-Payload Command Sequencer

This block runs one I2C command made of up to `NPAY` payloads by driving a byte-level bus engine one operation at a time. Each payload is fetched from a small indexed descriptor table: a 7-bit target address, a direction, a byte count and a base address into a byte buffer. Write payloads take their bytes from the buffer. Read payloads put the bytes they receive into the buffer.

A `go_i` pulse starts the command. The block first turns the requested bus speed into the engine's quarter-period delay, using a sequential divider. It then issues a start, the address byte and the data bytes for each payload in turn. Payloads are linked by repeated starts. A stop is issued only after the last payload, or straight after the first failure, which also ends the command. The whole command ends with a one-cycle `done_o` and a pass/fail flag.

The engine is driven through a request/response pair. `eng_req_o` is a one-cycle pulse that issues one operation. The engine later returns a one-cycle `eng_done_i` together with `eng_ok_i` and, for reads, `eng_rdata_i`.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Every engine operation carries `eng_qdelay_o` = max(1000 / S, 12) >> 2, using integer division, where S is `speed_i` sampled at `go_i`. A speed of 0 is replaced by 100.
- R2: Every payload begins with a start operation. The operation codes on `eng_op_o` are 0 start, 1 stop, 2 write byte, 3 read byte.
- R3: After a successful start, the first byte written is {address[6:0], dir}, with dir = 1 for a read and 0 for a write.
- R4: For a write payload of length L, after the address byte the block writes buffer bytes base+0 to base+L-1 in ascending order.
- R5: For a read payload of length L, after the address byte the block issues L read operations. `eng_more_o` = 1 on every read except the last one. Each read that succeeds is stored at buffer address base+i.
- R6: A payload that is not the last one ends without a stop, and the next payload follows with a (repeated) start.
- R7: After the last payload a stop is issued. When every operation succeeded, `done_o` pulses for one cycle with `pass_o` = 1.
- R8: A failed start, address or data operation is followed at once by a stop. The rest of that payload and all later payloads are skipped, and `pass_o` = 0.
- R9: A failed stop makes `pass_o` = 0.
- R10: After reset no request, no buffer write and no done is active. At most one engine operation is outstanding at a time, and each request lasts one cycle.
- R11: A command with zero payloads completes with `pass_o` = 1 and issues no engine operation.
- R12: `go_i` has no effect while a command is in progress: there is no extra operation and no second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Command start pulse |
| num_pay_i | input | NUM_W | Number of payloads (0..NPAY) |
| speed_i | input | SPD_W | Requested bus speed |
| desc_idx_o | output | PIDX_W | Descriptor table index |
| desc_addr_i | input | 7 | Payload target address |
| desc_rd_i | input | 1 | Payload direction, 1 = read |
| desc_len_i | input | LEN_W | Payload byte count |
| desc_base_i | input | BUF_AW | Payload buffer base |
| buf_addr_o | output | BUF_AW | Buffer byte address |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data (combinational) |
| eng_req_o | output | 1 | Engine operation request pulse |
| eng_op_o | output | 2 | Engine operation code |
| eng_wdata_o | output | 8 | Byte to write |
| eng_more_o | output | 1 | Read: acknowledge and expect more |
| eng_qdelay_o | output | QD_W | Quarter-period delay |
| eng_done_i | input | 1 | Engine operation complete pulse |
| eng_ok_i | input | 1 | Engine operation succeeded |
| eng_rdata_i | input | 8 | Byte read by engine |
| done_o | output | 1 | Command complete pulse |
| pass_o | output | 1 | Command result, valid with done |

## Verification
The assertions assume that the engine never raises `eng_done_i` in the same cycle as the request it answers, and never raises it without an outstanding request. They also assume that `num_pay_i` does not exceed `NPAY`. The bench's engine stub answers every request two cycles later and only then, and every command it issues uses between zero and three payloads. Failures are injected by operation index, so a start, address, data or stop step can each be made to fail.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_LOAD,
    ST_START,
    ST_ADDR,
    ST_DATA,
    ST_END,
    ST_STOP
  } seq_st_e;
endpackage

// File: rtl/i2c_seq_div.sv
module i2c_seq_div #(
  parameter int SPD_W     = 16,
  parameter int NUM       = 1000,
  parameter int MIN_DLY   = 12,
  parameter int DEF_SPEED = 100,
  localparam int Q_W      = $clog2(NUM + 1),
  localparam int QD_W     = Q_W - 2,
  localparam int CNT_W    = $clog2(Q_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic             done_o,
  output logic [QD_W-1:0]  qdelay_o
);
  logic [Q_W-1:0]   dvd_q, quo_q, quo_nx, full;
  logic [SPD_W:0]   rem_q, rem_sh, rem_nx;
  logic [SPD_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, take;

  // restoring divider, one quotient bit per cycle
  assign rem_sh = {rem_q[SPD_W-1:0], dvd_q[Q_W-1]};
  assign take   = rem_sh >= {1'b0, dvs_q};
  assign rem_nx = take ? rem_sh - {1'b0, dvs_q} : rem_sh;
  assign quo_nx = {quo_q[Q_W-2:0], take};
  assign full   = (quo_nx < Q_W'(MIN_DLY)) ? Q_W'(MIN_DLY) : quo_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q    <= '0;
      quo_q    <= '0;
      rem_q    <= '0;
      dvs_q    <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      done_o   <= 1'b0;
      qdelay_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        dvd_q <= Q_W'(NUM);
        quo_q <= '0;
        rem_q <= '0;
        dvs_q <= (speed_i == '0) ? SPD_W'(DEF_SPEED) : speed_i;
        cnt_q <= CNT_W'(Q_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        dvd_q <= {dvd_q[Q_W-2:0], 1'b0};
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q    <= 1'b0;
          done_o   <= 1'b1;
          qdelay_o <= full[Q_W-1:2];
        end
      end
    end
  end

  p_qdelay_floor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> qdelay_o >= QD_W'(MIN_DLY >> 2));
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int NPAY    = 4,
  parameter int LEN_W   = 4,
  parameter int BUF_AW  = 6,
  localparam int NUM_W  = $clog2(NPAY + 1),
  localparam int PIDX_W = $clog2(NPAY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [NUM_W-1:0]  num_pay_i,
  output logic              div_start_o,
  input  logic              div_done_i,
  output logic [PIDX_W-1:0] desc_idx_o,
  input  logic [6:0]        desc_addr_i,
  input  logic              desc_rd_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic [BUF_AW-1:0] desc_base_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [7:0]        eng_wdata_o,
  output logic              eng_more_o,
  input  logic              eng_done_i,
  input  logic              eng_ok_i,
  input  logic [7:0]        eng_rdata_i,
  output logic              done_o,
  output logic              pass_o
);
  seq_st_e           st_q;
  logic [NUM_W-1:0]  num_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [6:0]        addr7_q;
  logic              rd_q, mot_q, fail_q, issued_q, done_q, pass_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [BUF_AW-1:0] base_q;
  logic              op_st, fire, last_byte;

  assign op_st       = st_q inside {ST_START, ST_ADDR, ST_DATA, ST_STOP};
  assign eng_req_o   = op_st && !issued_q;
  assign fire        = issued_q && eng_done_i;
  assign last_byte   = (cnt_q + LEN_W'(1)) == len_q;
  assign desc_idx_o  = pidx_q;
  assign div_start_o = (st_q == ST_IDLE) && go_i;
  assign buf_addr_o  = base_q + BUF_AW'(cnt_q);
  assign buf_wdata_o = eng_rdata_i;
  assign buf_we_o    = (st_q == ST_DATA) && rd_q && fire && eng_ok_i;
  assign eng_more_o  = (st_q == ST_DATA) && rd_q && !last_byte;
  assign done_o      = done_q;
  assign pass_o      = pass_q;

  always_comb begin
    eng_op_o    = OP_START;
    eng_wdata_o = 8'h00;
    unique case (st_q)
      ST_ADDR: begin
        eng_op_o    = OP_WRITE;
        eng_wdata_o = {addr7_q, rd_q};
      end
      ST_DATA: begin
        eng_op_o    = rd_q ? OP_READ : OP_WRITE;
        eng_wdata_o = rd_q ? 8'h00 : buf_rdata_i;
      end
      ST_STOP: eng_op_o = OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      num_q    <= '0;
      pidx_q   <= '0;
      addr7_q  <= '0;
      rd_q     <= 1'b0;
      mot_q    <= 1'b0;
      fail_q   <= 1'b0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      len_q    <= '0;
      cnt_q    <= '0;
      base_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (eng_req_o) issued_q <= 1'b1;
      else if (eng_done_i) issued_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          num_q  <= num_pay_i;
          pidx_q <= '0;
          fail_q <= 1'b0;
          st_q   <= ST_DIV;
        end
        ST_DIV: if (div_done_i) begin
          if (num_q == '0) begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          addr7_q <= desc_addr_i;
          rd_q    <= desc_rd_i;
          len_q   <= desc_len_i;
          base_q  <= desc_base_i;
          cnt_q   <= '0;
          mot_q   <= (NUM_W'(pidx_q) + NUM_W'(1)) != num_q;
          st_q    <= ST_START;
        end
        ST_START: if (fire) begin
          fail_q <= !eng_ok_i;
          st_q   <= eng_ok_i ? ST_ADDR : ST_STOP;
        end
        ST_ADDR: if (fire) begin
          if (!eng_ok_i) begin
            fail_q <= 1'b1;
            st_q   <= ST_STOP;
          end else begin
            st_q <= (len_q == '0) ? ST_END : ST_DATA;
          end
        end
        ST_DATA: if (fire) begin
          if (!eng_ok_i) begin
            fail_q <= 1'b1;
            st_q   <= ST_STOP;
          end else if (last_byte) begin
            st_q <= ST_END;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        ST_END: begin
          if (mot_q) begin
            pidx_q <= pidx_q + PIDX_W'(1);
            st_q   <= ST_LOAD;
          end else begin
            st_q <= ST_STOP;
          end
        end
        ST_STOP: if (fire) begin
          done_q <= 1'b1;
          pass_q <= eng_ok_i && !fail_q;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_single_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |=> !eng_req_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fail_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_q && eng_done_i && !eng_ok_i && eng_op_o != OP_STOP)
      |=> (eng_req_o && eng_op_o == OP_STOP));
  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !eng_req_o);
  p_store_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (eng_op_o == OP_READ && eng_done_i));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int NPAY      = 4,
  parameter int LEN_W     = 4,
  parameter int BUF_AW    = 6,
  parameter int SPD_W     = 16,
  parameter int NUM       = 1000,
  parameter int MIN_DLY   = 12,
  parameter int DEF_SPEED = 100,
  localparam int NUM_W    = $clog2(NPAY + 1),
  localparam int PIDX_W   = $clog2(NPAY),
  localparam int QD_W     = $clog2(NUM + 1) - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [NUM_W-1:0]  num_pay_i,
  input  logic [SPD_W-1:0]  speed_i,
  output logic [PIDX_W-1:0] desc_idx_o,
  input  logic [6:0]        desc_addr_i,
  input  logic              desc_rd_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic [BUF_AW-1:0] desc_base_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [7:0]        eng_wdata_o,
  output logic              eng_more_o,
  output logic [QD_W-1:0]   eng_qdelay_o,
  input  logic              eng_done_i,
  input  logic              eng_ok_i,
  input  logic [7:0]        eng_rdata_i,
  output logic              done_o,
  output logic              pass_o
);
  logic div_start, div_done;

  i2c_seq_div #(
    .SPD_W(SPD_W), .NUM(NUM), .MIN_DLY(MIN_DLY), .DEF_SPEED(DEF_SPEED)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (div_start),
    .speed_i  (speed_i),
    .done_o   (div_done),
    .qdelay_o (eng_qdelay_o)
  );

  i2c_seq_ctrl #(
    .NPAY(NPAY), .LEN_W(LEN_W), .BUF_AW(BUF_AW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_i),
    .num_pay_i   (num_pay_i),
    .div_start_o (div_start),
    .div_done_i  (div_done),
    .desc_idx_o  (desc_idx_o),
    .desc_addr_i (desc_addr_i),
    .desc_rd_i   (desc_rd_i),
    .desc_len_i  (desc_len_i),
    .desc_base_i (desc_base_i),
    .buf_addr_o  (buf_addr_o),
    .buf_we_o    (buf_we_o),
    .buf_wdata_o (buf_wdata_o),
    .buf_rdata_i (buf_rdata_i),
    .eng_req_o   (eng_req_o),
    .eng_op_o    (eng_op_o),
    .eng_wdata_o (eng_wdata_o),
    .eng_more_o  (eng_more_o),
    .eng_done_i  (eng_done_i),
    .eng_ok_i    (eng_ok_i),
    .eng_rdata_i (eng_rdata_i),
    .done_o      (done_o),
    .pass_o      (pass_o)
  );
endmodule

// File: tb/i2c_cmd_seq_bench.sv
`timescale 1ns/1ps
module i2c_cmd_seq_bench;
  localparam int NPAY = 4;
  localparam int NUM_W = 3, PIDX_W = 2, LEN_W = 4, BUF_AW = 6, SPD_W = 16, QD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              go = 1'b0;
  logic [NUM_W-1:0]  num_pay = '0;
  logic [SPD_W-1:0]  speed = '0;
  logic [PIDX_W-1:0] desc_idx;
  logic [BUF_AW-1:0] buf_addr;
  logic              buf_we;
  logic [7:0]        buf_wdata;
  logic              eng_req, eng_more, done, pass;
  logic [1:0]        eng_op;
  logic [7:0]        eng_wdata;
  logic [QD_W-1:0]   eng_qdelay;
  logic              eng_done = 1'b0, eng_ok = 1'b0;
  logic [7:0]        eng_rdata = 8'h00;

  logic [6:0]        d_addr [NPAY];
  logic              d_rd   [NPAY];
  logic [LEN_W-1:0]  d_len  [NPAY];
  logic [BUF_AW-1:0] d_base [NPAY];
  logic [7:0]        mem     [64];
  logic [7:0]        exp_mem [64];

  i2c_cmd_seq u_i2c_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .num_pay_i(num_pay), .speed_i(speed),
    .desc_idx_o(desc_idx), .desc_addr_i(d_addr[desc_idx]), .desc_rd_i(d_rd[desc_idx]),
    .desc_len_i(d_len[desc_idx]), .desc_base_i(d_base[desc_idx]),
    .buf_addr_o(buf_addr), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .buf_rdata_i(mem[buf_addr]),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_wdata_o(eng_wdata),
    .eng_more_o(eng_more), .eng_qdelay_o(eng_qdelay), .eng_done_i(eng_done),
    .eng_ok_i(eng_ok), .eng_rdata_i(eng_rdata), .done_o(done), .pass_o(pass)
  );

  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  int n_chk = 0, n_err = 0;
  int q_op[$];
  int q_dat[$];
  bit q_more[$];
  string q_tag[$];
  int plan_k, op_seen, fail_at, exp_qd, done_cnt = 0, cd = 0;
  bit exp_pass, pend_ok;
  string pass_tag;
  logic [7:0] pend_rd;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rval(int k);
    return 8'(8'h3C + k * 29);
  endfunction

  function automatic bit push(int op, int dat, bit more, string tag);
    q_op.push_back(op);
    q_dat.push_back(dat);
    q_more.push_back(more);
    q_tag.push_back(tag);
    plan_k++;
    return (plan_k - 1) != fail_at;
  endfunction

  task automatic plan(int num, int spd, int fa);
    int d;
    bit bad;
    fail_at = fa; op_seen = 0; plan_k = 0;
    q_op.delete(); q_dat.delete(); q_more.delete(); q_tag.delete();
    d = 1000 / ((spd == 0) ? 100 : spd);
    if (d < 12) d = 12;
    exp_qd = d >> 2;
    bad = 1'b0;
    pass_tag = "R11";
    for (int p = 0; p < num; p++) begin
      if (!push(0, 0, 1'b0, (p > 0) ? "R6" : "R2")) bad = 1'b1;
      if (!bad && !push(2, {d_addr[p], d_rd[p]}, 1'b0, "R3")) bad = 1'b1;
      for (int i = 0; i < int'(d_len[p]) && !bad; i++) begin
        if (d_rd[p]) begin
          int k;
          k = plan_k;
          if (!push(3, 0, i != int'(d_len[p]) - 1, "R5")) bad = 1'b1;
          else exp_mem[int'(d_base[p]) + i] = rval(k);
        end else if (!push(2, exp_mem[int'(d_base[p]) + i], 1'b0, "R4")) bad = 1'b1;
      end
      if (bad || p == num - 1) begin
        pass_tag = bad ? "R8" : "R7";
        if (!push(1, 0, 1'b0, bad ? "R8" : "R7")) begin
          if (!bad) pass_tag = "R9";
          bad = 1'b1;
        end
        break;
      end
    end
    exp_pass = !bad;
  endtask

  // engine stub and per-cycle comparison against the expected operation list
  initial begin
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      if (rst_n && eng_req) begin
        chk(cd == 0, "R10", "request while busy", cd, 0);
        if (q_op.size() == 0) begin
          chk(1'b0, "R8", "unexpected op", int'(eng_op), -1);
        end else begin
          int eo, ed, act, exp;
          bit em;
          string et;
          eo = q_op.pop_front(); ed = q_dat.pop_front();
          em = q_more.pop_front(); et = q_tag.pop_front();
          act = int'(eng_op) * 512 + int'(eng_more) * 256 + ((eng_op == 2'd2) ? int'(eng_wdata) : 0);
          exp = eo * 512 + int'(em) * 256 + ((eo == 2) ? ed : 0);
          chk(act == exp, et, "op/more/data", act, exp);
          chk(int'(eng_qdelay) == exp_qd, "R1", "qdelay", int'(eng_qdelay), exp_qd);
        end
        pend_ok = (op_seen != fail_at);
        pend_rd = rval(op_seen);
        op_seen++;
        cd = 2;
      end else if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          eng_done = 1'b1;
          eng_ok = pend_ok;
          eng_rdata = pend_rd;
        end
      end
      if (rst_n && done) begin
        done_cnt++;
        chk(pass == exp_pass, pass_tag, "pass", int'(pass), int'(exp_pass));
        chk(q_op.size() == 0, "R8", "ops left at done", q_op.size(), 0);
      end
    end
  end

  task automatic set_pay(int p, int a, bit rd, int len, int base);
    d_addr[p] = 7'(a); d_rd[p] = rd; d_len[p] = 4'(len); d_base[p] = 6'(base);
  endtask

  task automatic run_cmd(int num, int spd, int fa, bit regos, string tag);
    int d0, t;
    int bad_bytes;
    plan(num, spd, fa);
    d0 = done_cnt;
    @(negedge clk);
    num_pay = 3'(num); speed = 16'(spd); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (regos) begin
      repeat (6) @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done_cnt == d0 + 1, tag, "done seen", done_cnt - d0, 1);
    repeat (20) @(negedge clk);
    chk(done_cnt == d0 + 1, "R12", "single done", done_cnt - d0, 1);
    bad_bytes = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) bad_bytes++;
    chk(bad_bytes == 0, "R5", "buffer mismatches", bad_bytes, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 1);
      exp_mem[i] = 8'(i * 7 + 1);
    end
    for (int p = 0; p < NPAY; p++) set_pay(p, 0, 1'b0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!eng_req && !buf_we && !done, "R10", "reset quiet",
        int'({eng_req, buf_we, done}), 0);

    // single write, default-like speed
    set_pay(0, 7'h50, 1'b0, 3, 0);
    run_cmd(1, 100, -1, 1'b0, "R7");

    // write then read chained by repeated start, go pulsed while busy
    set_pay(0, 7'h21, 1'b0, 2, 4);
    set_pay(1, 7'h21, 1'b1, 3, 16);
    run_cmd(2, 50, -1, 1'b1, "R6");

    // zero-length read then single-byte read, speed 0 uses default
    set_pay(0, 7'h7F, 1'b1, 0, 30);
    set_pay(1, 7'h7F, 1'b1, 1, 20);
    run_cmd(2, 0, -1, 1'b0, "R1");

    // address NACK on second of three payloads, slowest speed
    set_pay(0, 7'h10, 1'b0, 1, 8);
    set_pay(1, 7'h11, 1'b0, 2, 9);
    set_pay(2, 7'h12, 1'b1, 2, 40);
    run_cmd(3, 1, 4, 1'b0, "R8");

    // start failure on first payload
    set_pay(0, 7'h33, 1'b0, 2, 0);
    run_cmd(1, 400, 0, 1'b0, "R8");

    // stop failure
    set_pay(0, 7'h44, 1'b0, 2, 2);
    run_cmd(1, 100, 4, 1'b0, "R9");

    // zero payloads
    run_cmd(0, 7, -1, 1'b0, "R11");

    // read byte failure mid-payload, speed above the floor
    set_pay(0, 7'h05, 1'b1, 3, 48);
    run_cmd(1, 3000, 3, 1'b0, "R8");

    // three clean payloads mixing directions
    set_pay(0, 7'h60, 1'b1, 2, 56);
    set_pay(1, 7'h61, 1'b0, 2, 56);
    set_pay(2, 7'h62, 1'b1, 1, 60);
    run_cmd(3, 83, -1, 1'b0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule